// File: doc/BRIEF.md
# PWM Timebase Counter with Shadowed Parameters

This block is the time base that a set of PWM channels compares against. A 20-bit counter steps up by one on every cycle where the divider tick is present and the counter is not paused. It climbs to a programmable power-of-two limit, returns to zero and marks that return with a one-cycle overflow pulse. Software may clear the counter, pause it, and read it back from the count output at any time.

The resolution and the fractional divisor are not used directly from the configuration inputs. A write first places them in a staging register. From there they move to the active copy in one of two ways. In automatic mode the move happens on the cycle the counter wraps, so a period is never cut short by a change. In manual mode the move happens only on a cycle where the one-cycle update strobe is high. The active divisor is driven out for the divider that feeds the tick input.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, the overflow output is low and the active divisor equals 18'h00100 (active resolution 8).
- R2: The count rises by exactly one on a cycle with tick_i high and hold_i low. On any other cycle without clr_i it keeps its value.
- R3: When the count is at 2^RES-1 and advances, it becomes 0 on the next cycle and ovf_o is high for that single cycle. ovf_o is low at all other times.
- R4: The active resolution field is 5 bits. A value of 0 acts as 1 (wrap after count 1). Any value above 20 acts as 20, so the count passes 65535 without wrapping.
- R5: clr_i forces the count to 0 on the next cycle, even when a tick arrives at the limit in the same cycle. It raises no overflow and commits no parameters.
- R6: With manual_i low, the staged values become active on the wrap edge only. The new divisor is visible in the same cycle as ovf_o, and upd_i has no effect.
- R7: With manual_i high, the staged values become active on the edge where upd_i is high. The divisor is visible on the next cycle, and wraps commit nothing.
- R8: cfg_we_i loads res_i and div_i into the staging register. If that load happens in the same cycle as a commit, the active copy takes the previously staged values, and the new ones wait for the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Divider tick, counter advance enable |
| hold_i | input | 1 | Pause the counter |
| clr_i | input | 1 | Return the counter to zero |
| manual_i | input | 1 | 0: commit at wrap, 1: commit on upd_i |
| upd_i | input | 1 | One-cycle commit strobe (manual mode) |
| cfg_we_i | input | 1 | Load res_i and div_i into staging |
| res_i | input | 5 | Resolution in bits, 1..20 |
| div_i | input | 18 | Divisor, 10 integer bits and 8 fraction bits |
| cnt_o | output | 20 | Current count |
| ovf_o | output | 1 | Pulse on the cycle after a wrap |
| div_act_o | output | 18 | Divisor currently in force |

## Verification
Two collisions matter most. The first is a configuration write landing on the same edge as an automatic wrap commit. The bench drives cfg_we_i together with the tick that takes the count from its limit to zero. It expects the divisor output to show the value staged earlier, and it expects the freshly written value to appear only one full period later. The second is a clear arriving with a tick at the limit. Here the bench expects a zero count with no overflow pulse and an unchanged divisor, and it expects the pending values to commit at the next genuine wrap.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
  localparam int CNT_W = 20;
  localparam int RES_W = 5;
  localparam int DIV_W = 18;

  // Legal resolution window is 1..CNT_W
  function automatic logic [RES_W-1:0] res_clamp(input logic [RES_W-1:0] r);
    if (r == '0) return RES_W'(1);
    if (int'(r) > CNT_W) return RES_W'(CNT_W);
    return r;
  endfunction

  // Highest count before wrapping: 2^res - 1
  function automatic logic [CNT_W-1:0] wrap_limit(input logic [RES_W-1:0] r);
    int k;
    k = int'(res_clamp(r));
    return {CNT_W{1'b1}} >> (CNT_W - k);
  endfunction
endpackage

// File: rtl/pwm_timebase_shadow.sv
module pwm_timebase_shadow #(
  parameter int RES_W = 5,
  parameter int DIV_W = 18,
  parameter logic [RES_W-1:0] RES_RST = 5'd8,
  parameter logic [DIV_W-1:0] DIV_RST = 18'h00100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [RES_W-1:0] res_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             commit_i,
  output logic [RES_W-1:0] res_act_o,
  output logic [DIV_W-1:0] div_act_o
);
  logic [RES_W-1:0] res_stg;
  logic [DIV_W-1:0] div_stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_stg <= RES_RST;
      div_stg <= DIV_RST;
    end else if (we_i) begin
      res_stg <= res_i;
      div_stg <= div_i;
    end
  end

  // Commit reads the staged copy as it stood before this edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_act_o <= RES_RST;
      div_act_o <= DIV_RST;
    end else if (commit_i) begin
      res_act_o <= res_stg;
      div_act_o <= div_stg;
    end
  end
endmodule

// File: rtl/pwm_timebase_count.sv
module pwm_timebase_count
  import pwm_timebase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             clr_i,
  input  logic [RES_W-1:0] res_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             adv_o,
  output logic             at_max_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] limit;

  assign limit    = wrap_limit(res_i);
  assign adv_o    = tick_i & ~hold_i;
  // >= so a count left above a freshly shrunk limit still wraps
  assign at_max_o = (cnt_o >= limit);
  assign wrap_o   = adv_o & at_max_o & ~clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      ovf_o <= wrap_o;
      if (clr_i || wrap_o) cnt_o <= '0;
      else if (adv_o)      cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter logic [RES_W-1:0] RES_RST = 5'd8,
  parameter logic [DIV_W-1:0] DIV_RST = 18'h00100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             clr_i,
  input  logic             manual_i,
  input  logic             upd_i,
  input  logic             cfg_we_i,
  input  logic [RES_W-1:0] res_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic [DIV_W-1:0] div_act_o
);
  logic             adv_w;
  logic             at_max_w;
  logic             wrap_w;
  logic             commit_w;
  logic [RES_W-1:0] res_act_w;

  assign commit_w = manual_i ? upd_i : wrap_w;

  pwm_timebase_shadow #(
    .RES_W(RES_W), .DIV_W(DIV_W), .RES_RST(RES_RST), .DIV_RST(DIV_RST)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .res_i(res_i), .div_i(div_i),
    .commit_i(commit_w), .res_act_o(res_act_w), .div_act_o(div_act_o)
  );

  pwm_timebase_count u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hold_i(hold_i), .clr_i(clr_i),
    .res_i(res_act_w), .cnt_o(cnt_o), .ovf_o(ovf_o), .adv_o(adv_w),
    .at_max_o(at_max_w), .wrap_o(wrap_w)
  );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
  import pwm_timebase_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             clr_i,
  input logic             manual_i,
  input logic             upd_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             ovf_o,
  input logic [DIV_W-1:0] div_act_o,
  input logic             adv_w,
  input logic             at_max_w,
  input logic             wrap_w
);
  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0) && !ovf_o); // R5
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_w && !clr_i) |=> $stable(cnt_o)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_w && !clr_i && !at_max_w) |=> cnt_o == $past(cnt_o) + CNT_W'(1)); // R2
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_w |=> ovf_o && (cnt_o == '0)); // R3
  AST_FLAG_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_w |=> !ovf_o); // R3
  AST_AUTO_HOLD_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_i && !wrap_w) |=> $stable(div_act_o)); // R6
  AST_MANUAL_HOLD_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (manual_i && !upd_i) |=> $stable(div_act_o)); // R7
endmodule

bind pwm_timebase pwm_timebase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .manual_i(manual_i), .upd_i(upd_i),
  .cnt_o(cnt_o), .ovf_o(ovf_o), .div_act_o(div_act_o), .adv_w(adv_w),
  .at_max_w(at_max_w), .wrap_w(wrap_w)
);

// File: tb/sim_pwm_timebase.sv
module sim_pwm_timebase;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, hold = 1'b0, clr = 1'b0, manual = 1'b0, upd = 1'b0, we = 1'b0;
  logic [4:0]  res = '0;
  logic [17:0] div = '0;
  logic [19:0] cnt;
  logic        ovf;
  logic [17:0] dact;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  pwm_timebase u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .hold_i(hold), .clr_i(clr),
    .manual_i(manual), .upd_i(upd), .cfg_we_i(we), .res_i(res), .div_i(div),
    .cnt_o(cnt), .ovf_o(ovf), .div_act_o(dact)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h, expected %0h", req, what, act, exp);
    end
  endtask

  // One cycle with the given controls; outputs sampled 1 time unit after the edge
  task automatic step(input logic t, input logic h, input logic c, input logic u);
    tick = t; hold = h; clr = c; upd = u;
    @(posedge clk); #1;
    tick = 0; hold = 0; clr = 0; upd = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0);
  endtask

  task automatic wr(input logic [4:0] r, input logic [17:0] d);
    we = 1; res = r; div = d;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic t_reset;
    chk("R1", "count", 32'(cnt), 0);
    chk("R1", "ovf", 32'(ovf), 0);
    chk("R1", "divisor", 32'(dact), 32'h100);
  endtask

  task automatic t_count;
    manual = 1;
    wr(3, 18'h100); step(0, 0, 0, 1); step(0, 0, 1, 0);
    ticks(5); chk("R2", "count after 5", 32'(cnt), 5);
    ticks(2); chk("R3", "count at limit", 32'(cnt), 7); chk("R3", "ovf early", 32'(ovf), 0);
    ticks(1); chk("R3", "count wrapped", 32'(cnt), 0); chk("R3", "ovf at wrap", 32'(ovf), 1);
    step(0, 0, 0, 0); chk("R3", "ovf one cycle", 32'(ovf), 0);
  endtask

  task automatic t_hold;
    step(0, 0, 1, 0); ticks(2);
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0);
    chk("R2", "hold with tick", 32'(cnt), 2);
    step(0, 0, 0, 0); chk("R2", "no tick", 32'(cnt), 2);
    ticks(1); chk("R2", "resume", 32'(cnt), 3);
  endtask

  task automatic t_clamp;
    int seen;
    wr(0, 18'h100); step(0, 0, 0, 1); step(0, 0, 1, 0);
    ticks(1); chk("R4", "res0 count", 32'(cnt), 1);
    ticks(1); chk("R4", "res0 wrap", 32'(cnt), 0); chk("R4", "res0 ovf", 32'(ovf), 1);
    wr(31, 18'h100); step(0, 0, 0, 1); step(0, 0, 1, 0);
    seen = 0;
    for (int i = 0; i < 66000; i++) begin
      step(1, 0, 0, 0);
      if (ovf) seen++;
    end
    chk("R4", "res31 no wrap", 32'(seen), 0);
    chk("R4", "res31 count", 32'(cnt), 66000);
  endtask

  task automatic t_manual;
    wr(2, 18'h100); step(0, 0, 0, 1); step(0, 0, 1, 0);
    wr(2, 18'h2C0);
    ticks(4);
    chk("R7", "wrap ovf", 32'(ovf), 1);
    chk("R7", "no commit at wrap", 32'(dact), 32'h100);
    step(0, 0, 0, 1); chk("R7", "commit on strobe", 32'(dact), 32'h2C0);
  endtask

  task automatic t_auto;
    manual = 0;
    wr(3, 18'h305); step(0, 0, 1, 0);
    step(0, 0, 0, 1); chk("R6", "strobe ignored", 32'(dact), 32'h2C0);
    ticks(3); chk("R6", "before wrap", 32'(dact), 32'h2C0);
    ticks(1); chk("R6", "wrap count", 32'(cnt), 0);
    chk("R6", "divisor at wrap", 32'(dact), 32'h305);
    ticks(7); chk("R6", "new limit reached", 32'(cnt), 7);
    ticks(1); chk("R6", "new limit wrap", 32'(ovf), 1);
  endtask

  task automatic t_collide;
    ticks(7);
    we = 1; res = 1; div = 18'h1AB;
    step(1, 0, 0, 0); we = 0;
    chk("R8", "collide ovf", 32'(ovf), 1);
    chk("R8", "old staged wins", 32'(dact), 32'h305);
    ticks(7); chk("R8", "limit kept", 32'(cnt), 7);
    ticks(1); chk("R8", "late commit", 32'(dact), 32'h1AB);
    ticks(1); chk("R8", "res1 top", 32'(cnt), 1);
    ticks(1); chk("R8", "res1 wrap", 32'(ovf), 1);
  endtask

  task automatic t_clr;
    wr(2, 18'h0CC);
    ticks(1); chk("R5", "at limit", 32'(cnt), 1);
    step(1, 0, 1, 0);
    chk("R5", "cleared", 32'(cnt), 0);
    chk("R5", "no ovf", 32'(ovf), 0);
    chk("R5", "no commit", 32'(dact), 32'h1AB);
    ticks(2); chk("R5", "real wrap commits", 32'(dact), 32'h0CC);
    chk("R5", "real wrap ovf", 32'(ovf), 1);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_count;
    t_hold;
    t_clamp;
    t_manual;
    t_auto;
    t_collide;
    t_clr;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule